// File: doc/BRIEF.md
# SD Host Received-Frame Error Checker

This block judges every frame the host side of an SD link takes in, once the framing logic has finished collecting it. There are three frame types: a command response on the command line, a read data block on the data lines, and the three-bit status token that the card returns after each written block. The deserialiser and the CRC generators run upstream of this block. For each frame they pass in one strobe together with the received fields, the bit counts and the CRC values they computed. The checker compares these fields with what the frame should contain and records every problem in a sticky status bit.

There are ten detailed error bits. Three summary flags are formed from them: framing, CRC and command index. The summary flags are combined with an enable mask into one interrupt request. Response errors are tracked twice over. One set of bits is kept for a stop command that the host issued automatically, and a second set for every other command, so software can tell a failed stop from a failed transfer command. All detailed bits are cleared when software writes a new command or when the block is held in its software reset state.

Top module: `sdc_frame_err`

## Requirements
- R1: After reset, `err_detail`, `err_sum` and `irq` are all zero.
- R2: A response has an expected length of 136 bits when `rsp_kind`=1 and 48 bits for any other kind. A strobed response whose `rsp_len` differs from this, or whose `rsp_end` is 0, sets detail bit 1 when `rsp_auto`=1 and detail bit 0 otherwise.
- R3: A response of kind 0 or 3 whose `rsp_crc_rx` differs from `rsp_crc_calc` sets detail bit 5 when `rsp_auto`=1 and detail bit 4 otherwise.
- R4: A response of kind 0 or 3 whose `rsp_idx` differs from `cmd_idx` sets detail bit 9 when `rsp_auto`=1 and detail bit 8 otherwise. For kinds 1 and 2 the index and CRC are not checked.
- R5: A read block has an expected per-lane length of `rd_blk_bytes`*8+16 bits in narrow mode and `rd_blk_bytes`*8/4+16 bits in wide mode (`rd_wide`=1). A different `rd_len`, or a 0 on the `rd_end` bit of any active lane, sets detail bit 2. Lane 0 is the only active lane in narrow mode; lanes 0 to 3 are active in wide mode.
- R6: A CRC mismatch on any active read lane sets detail bit 6. Lane n uses bits [16n+15:16n] of `rd_crc_rx` and `rd_crc_calc`. Mismatches on inactive lanes are ignored.
- R7: A status token whose `tok_len` is not 3, or whose `tok_end` is 0, sets detail bit 3. A token pattern other than 3'b010 sets detail bit 7.
- R8: `err_sum[0]` is the OR of detail bits 3:0, `err_sum[1]` the OR of bits 7:4, and `err_sum[2]` the OR of bits 9:8. `irq` is high when any bit of `err_sum & irq_en` is set.
- R9: Once a detail bit is set it stays set, even after later good frames, until a clear event.
- R10: A clock edge with `cmd_wr`=1 or `core_run`=0 clears every detail bit. An error strobed at the same edge is still recorded.
- R11: A strobe sampled at a rising clock edge updates the outputs at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_run | input | 1 | Block run control; 0 holds the detail bits cleared |
| cmd_wr | input | 1 | Pulse when software writes a new command |
| cmd_idx | input | 6 | Index of the command that was sent |
| rsp_done | input | 1 | Response frame complete strobe |
| rsp_auto | input | 1 | Response belongs to an automatically issued stop command |
| rsp_kind | input | 2 | 0/3 indexed 48-bit, 1 long 136-bit, 2 short without index |
| rsp_len | input | 8 | Received response length in bits |
| rsp_end | input | 1 | Sampled end bit of the response |
| rsp_idx | input | 6 | Index field in the response |
| rsp_crc_rx | input | 7 | CRC7 carried in the response |
| rsp_crc_calc | input | 7 | CRC7 computed over the response |
| rd_done | input | 1 | Read block complete strobe |
| rd_wide | input | 1 | Four data lanes in use |
| rd_blk_bytes | input | BLK_W | Block length in bytes |
| rd_len | input | LEN_W | Bits counted per lane between start and end bit |
| rd_end | input | LANES | Sampled end bit on each lane |
| rd_crc_rx | input | LANES*16 | CRC16 received on each lane |
| rd_crc_calc | input | LANES*16 | CRC16 computed for each lane |
| tok_done | input | 1 | Status token complete strobe |
| tok_len | input | 3 | Token bits counted between start and end bit |
| tok_end | input | 1 | Sampled end bit of the token |
| tok_bits | input | 3 | Received token pattern |
| irq_en | input | 3 | Enable mask for the summary flags |
| err_detail | output | 10 | Sticky detailed error bits |
| err_sum | output | 3 | Summary flags: framing, CRC, index |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each strobe lasts one cycle and that its fields are valid while the strobe is high. They also assume that `rsp_auto` means something only together with `rsp_done`. The bench changes inputs only on the falling clock edge and raises each strobe for exactly one cycle, so all of these assumptions hold. Between scenarios it clears the block with a command write, so each check covers one frame only. The exceptions are the sticky-bit and same-edge tests, which layer frames on purpose.

// File: rtl/sdc_err_pkg.sv
package sdc_err_pkg;

  localparam int DET_W = 10;
  localparam int SUM_W = 3;

  localparam int B_RSPLEN_N = 0;
  localparam int B_RSPLEN_A = 1;
  localparam int B_RDLEN    = 2;
  localparam int B_TOKLEN   = 3;
  localparam int B_RSPCRC_N = 4;
  localparam int B_RSPCRC_A = 5;
  localparam int B_RDCRC    = 6;
  localparam int B_TOKCRC   = 7;
  localparam int B_IDX_N    = 8;
  localparam int B_IDX_A    = 9;

  typedef enum logic [1:0] {
    RK_INDEXED = 2'd0,
    RK_LONG    = 2'd1,
    RK_BARE    = 2'd2,
    RK_INDEXED2 = 2'd3
  } rsp_kind_t;

  function automatic logic [7:0] rsp_len_expect(input logic [1:0] kind);
    return (kind == RK_LONG) ? 8'd136 : 8'd48;
  endfunction

  function automatic logic kind_checks_body(input logic [1:0] kind);
    return !(kind == RK_LONG || kind == RK_BARE);
  endfunction

  function automatic logic tok_pattern_ok(input logic [2:0] b);
    return b == 3'b010;
  endfunction

endpackage

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check
  import sdc_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic       auto_stop,
  input  logic [1:0] kind,
  input  logic [7:0] len,
  input  logic       end_bit,
  input  logic [5:0] idx_rx,
  input  logic [5:0] idx_tx,
  input  logic [6:0] crc_rx,
  input  logic [6:0] crc_calc,
  output logic       len_err_n,
  output logic       len_err_a,
  output logic       crc_err_n,
  output logic       crc_err_a,
  output logic       idx_err_n,
  output logic       idx_err_a
);

  logic len_bad, crc_bad, idx_bad, body_on;
  logic any_auto, any_norm;

  always_comb begin
    body_on = kind_checks_body(kind);
    len_bad = (len != rsp_len_expect(kind)) || !end_bit;
    crc_bad = body_on && (crc_rx != crc_calc);
    idx_bad = body_on && (idx_rx != idx_tx);
  end

  assign len_err_n = done && !auto_stop && len_bad;
  assign len_err_a = done &&  auto_stop && len_bad;
  assign crc_err_n = done && !auto_stop && crc_bad;
  assign crc_err_a = done &&  auto_stop && crc_bad;
  assign idx_err_n = done && !auto_stop && idx_bad;
  assign idx_err_a = done &&  auto_stop && idx_bad;

  assign any_auto = len_err_a | crc_err_a | idx_err_a;
  assign any_norm = len_err_n | crc_err_n | idx_err_n;

  p_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({any_auto, any_norm}));

  p_bare_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (kind == RK_LONG || kind == RK_BARE)) |->
      !(idx_err_n || idx_err_a || crc_err_n || crc_err_a));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(any_auto || any_norm));

endmodule

// File: rtl/sdc_dat_check.sv
module sdc_dat_check #(
  parameter int LANES = 4,
  parameter int BLK_W = 10,
  parameter int LEN_W = BLK_W + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done,
  input  logic                  wide,
  input  logic [BLK_W-1:0]      blk_bytes,
  input  logic [LEN_W-1:0]      len,
  input  logic [LANES-1:0]      end_bits,
  input  logic [LANES*16-1:0]   crc_rx,
  input  logic [LANES*16-1:0]   crc_calc,
  output logic                  len_err,
  output logic                  crc_err
);

  logic [LANES-1:0] lane_act, lane_crc_bad, lane_end_bad;
  logic [LEN_W-1:0] len_exp;

  function automatic logic [LEN_W-1:0] data_len_expect(
    input logic wide_m, input logic [BLK_W-1:0] nbytes);
    logic [LEN_W-1:0] bits;
    bits = LEN_W'(nbytes) << 3;
    if (wide_m) bits = bits / LEN_W'(LANES);
    return bits + LEN_W'(16);
  endfunction

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign lane_act[g] = 1'b1;
      end else begin : g_other
        assign lane_act[g] = wide;
      end
      assign lane_crc_bad[g] = lane_act[g] &&
        (crc_rx[g*16 +: 16] != crc_calc[g*16 +: 16]);
      assign lane_end_bad[g] = lane_act[g] && !end_bits[g];
    end
  endgenerate

  assign len_exp = data_len_expect(wide, blk_bytes);
  assign len_err = done && ((len != len_exp) || (|lane_end_bad));
  assign crc_err = done && (|lane_crc_bad);

  p_narrow_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide && crc_rx[15:0] == crc_calc[15:0]) |-> !crc_err);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(len_err || crc_err));

endmodule

// File: rtl/sdc_tok_check.sv
module sdc_tok_check
  import sdc_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [2:0] len,
  input  logic       end_bit,
  input  logic [2:0] bits,
  output logic       len_err,
  output logic       crc_err
);

  assign len_err = done && ((len != 3'd3) || !end_bit);
  assign crc_err = done && !tok_pattern_ok(bits);

  p_good_pat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bits == 3'b010) |-> !crc_err);

endmodule

// File: rtl/sdc_err_reg.sv
module sdc_err_reg
  import sdc_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_evt,
  input  logic [DET_W-1:0] set_vec,
  input  logic [SUM_W-1:0] irq_en,
  output logic [DET_W-1:0] det_q,
  output logic [SUM_W-1:0] sum,
  output logic             irq
);

  logic [DET_W-1:0] det_d;

  always_comb begin
    if (clr_evt) det_d = set_vec;
    else         det_d = det_q | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_q <= '0;
    else        det_q <= det_d;
  end

  always_comb begin
    sum[0] = |det_q[B_TOKLEN:B_RSPLEN_N];
    sum[1] = |det_q[B_TOKCRC:B_RSPCRC_N];
    sum[2] = |det_q[B_IDX_A:B_IDX_N];
  end

  assign irq = |(sum & irq_en);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> ((det_q & $past(det_q)) == $past(det_q)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && set_vec == '0) |=> det_q == '0);

  p_new_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((det_q & $past(set_vec)) == $past(set_vec)));

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (det_q != '0));

endmodule

// File: rtl/sdc_frame_err.sv
module sdc_frame_err
  import sdc_err_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BLK_W = 10,
  parameter int LEN_W = BLK_W + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_run,
  input  logic                 cmd_wr,
  input  logic [5:0]           cmd_idx,
  input  logic                 rsp_done,
  input  logic                 rsp_auto,
  input  logic [1:0]           rsp_kind,
  input  logic [7:0]           rsp_len,
  input  logic                 rsp_end,
  input  logic [5:0]           rsp_idx,
  input  logic [6:0]           rsp_crc_rx,
  input  logic [6:0]           rsp_crc_calc,
  input  logic                 rd_done,
  input  logic                 rd_wide,
  input  logic [BLK_W-1:0]     rd_blk_bytes,
  input  logic [LEN_W-1:0]     rd_len,
  input  logic [LANES-1:0]     rd_end,
  input  logic [LANES*16-1:0]  rd_crc_rx,
  input  logic [LANES*16-1:0]  rd_crc_calc,
  input  logic                 tok_done,
  input  logic [2:0]           tok_len,
  input  logic                 tok_end,
  input  logic [2:0]           tok_bits,
  input  logic [2:0]           irq_en,
  output logic [9:0]           err_detail,
  output logic [2:0]           err_sum,
  output logic                 irq
);

  logic rsp_len_n, rsp_len_a, rsp_crc_n, rsp_crc_a, rsp_idx_n, rsp_idx_a;
  logic rd_len_e, rd_crc_e, tok_len_e, tok_crc_e;
  logic clr_evt;
  logic [DET_W-1:0] set_vec;

  sdc_rsp_check u_rsp (
    .clk(clk), .rst_n(rst_n), .done(rsp_done), .auto_stop(rsp_auto),
    .kind(rsp_kind), .len(rsp_len), .end_bit(rsp_end), .idx_rx(rsp_idx),
    .idx_tx(cmd_idx), .crc_rx(rsp_crc_rx), .crc_calc(rsp_crc_calc),
    .len_err_n(rsp_len_n), .len_err_a(rsp_len_a),
    .crc_err_n(rsp_crc_n), .crc_err_a(rsp_crc_a),
    .idx_err_n(rsp_idx_n), .idx_err_a(rsp_idx_a)
  );

  sdc_dat_check #(.LANES(LANES), .BLK_W(BLK_W), .LEN_W(LEN_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .done(rd_done), .wide(rd_wide),
    .blk_bytes(rd_blk_bytes), .len(rd_len), .end_bits(rd_end),
    .crc_rx(rd_crc_rx), .crc_calc(rd_crc_calc),
    .len_err(rd_len_e), .crc_err(rd_crc_e)
  );

  sdc_tok_check u_tok (
    .clk(clk), .rst_n(rst_n), .done(tok_done), .len(tok_len),
    .end_bit(tok_end), .bits(tok_bits),
    .len_err(tok_len_e), .crc_err(tok_crc_e)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[B_RSPLEN_N] = rsp_len_n;
    set_vec[B_RSPLEN_A] = rsp_len_a;
    set_vec[B_RDLEN]    = rd_len_e;
    set_vec[B_TOKLEN]   = tok_len_e;
    set_vec[B_RSPCRC_N] = rsp_crc_n;
    set_vec[B_RSPCRC_A] = rsp_crc_a;
    set_vec[B_RDCRC]    = rd_crc_e;
    set_vec[B_TOKCRC]   = tok_crc_e;
    set_vec[B_IDX_N]    = rsp_idx_n;
    set_vec[B_IDX_A]    = rsp_idx_a;
  end

  assign clr_evt = cmd_wr || !core_run;

  sdc_err_reg u_reg (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .set_vec(set_vec),
    .irq_en(irq_en), .det_q(err_detail), .sum(err_sum), .irq(irq)
  );

  p_halt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_run && !rsp_done && !rd_done && !tok_done) |=> err_detail == '0);

endmodule

// File: tb/sdc_frame_err_test.sv
module sdc_frame_err_test;

  localparam int PERIOD = 10;
  localparam int LANES = 4;
  localparam int BLK_W = 10;
  localparam int LEN_W = BLK_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_run = 1'b1, cmd_wr = 1'b0;
  logic [5:0] cmd_idx = 6'd17;
  logic rsp_done = 1'b0, rsp_auto = 1'b0, rsp_end = 1'b1;
  logic [1:0] rsp_kind = 2'd0;
  logic [7:0] rsp_len = 8'd48;
  logic [5:0] rsp_idx = 6'd17;
  logic [6:0] rsp_crc_rx = 7'h2a, rsp_crc_calc = 7'h2a;
  logic rd_done = 1'b0, rd_wide = 1'b0;
  logic [BLK_W-1:0] rd_blk_bytes = 10'd512;
  logic [LEN_W-1:0] rd_len = 14'd4112;
  logic [LANES-1:0] rd_end = 4'hf;
  logic [LANES*16-1:0] rd_crc_rx = 64'h1111_2222_3333_4444;
  logic [LANES*16-1:0] rd_crc_calc = 64'h1111_2222_3333_4444;
  logic tok_done = 1'b0, tok_end = 1'b1;
  logic [2:0] tok_len = 3'd3, tok_bits = 3'b010;
  logic [2:0] irq_en = 3'b000;
  logic [9:0] err_detail;
  logic [2:0] err_sum;
  logic irq;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  sdc_frame_err #(.LANES(LANES), .BLK_W(BLK_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .core_run(core_run), .cmd_wr(cmd_wr),
    .cmd_idx(cmd_idx), .rsp_done(rsp_done), .rsp_auto(rsp_auto),
    .rsp_kind(rsp_kind), .rsp_len(rsp_len), .rsp_end(rsp_end),
    .rsp_idx(rsp_idx), .rsp_crc_rx(rsp_crc_rx), .rsp_crc_calc(rsp_crc_calc),
    .rd_done(rd_done), .rd_wide(rd_wide), .rd_blk_bytes(rd_blk_bytes),
    .rd_len(rd_len), .rd_end(rd_end), .rd_crc_rx(rd_crc_rx),
    .rd_crc_calc(rd_crc_calc), .tok_done(tok_done), .tok_len(tok_len),
    .tok_end(tok_end), .tok_bits(tok_bits), .irq_en(irq_en),
    .err_detail(err_detail), .err_sum(err_sum), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear_all();
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic send_rsp(input logic au, input logic [1:0] kd,
                          input logic [7:0] ln, input logic eb,
                          input logic [5:0] ix, input logic [6:0] cr);
    rsp_auto = au; rsp_kind = kd; rsp_len = ln; rsp_end = eb;
    rsp_idx = ix; rsp_crc_rx = cr; rsp_crc_calc = 7'h2a;
    rsp_done = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0; rsp_auto = 1'b0;
  endtask

  task automatic send_rd(input logic wd, input logic [LEN_W-1:0] ln,
                         input logic [LANES-1:0] eb,
                         input logic [LANES*16-1:0] flip);
    rd_wide = wd; rd_len = ln; rd_end = eb;
    rd_crc_rx = rd_crc_calc ^ flip;
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic send_tok(input logic [2:0] ln, input logic eb,
                          input logic [2:0] b);
    tok_len = ln; tok_end = eb; tok_bits = b;
    tok_done = 1'b1;
    @(negedge clk);
    tok_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 detail", 32'(err_detail), 32'h0);
    check("R1 sum", 32'(err_sum), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_rsp();
    clear_all(); send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd17, 7'h2a);
    check("R2 good response", 32'(err_detail), 32'h0);
    clear_all(); send_rsp(1'b1, 2'd0, 8'd47, 1'b1, 6'd17, 7'h2a);
    check("R2 auto length", 32'(err_detail), 32'h002);
    clear_all(); send_rsp(1'b0, 2'd3, 8'd48, 1'b0, 6'd17, 7'h2a);
    check("R2 normal end bit", 32'(err_detail), 32'h001);
    clear_all(); send_rsp(1'b0, 2'd1, 8'd48, 1'b1, 6'd17, 7'h2a);
    check("R2 long kind short length", 32'(err_detail), 32'h001);
    clear_all(); send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd17, 7'h15);
    check("R3 normal crc", 32'(err_detail), 32'h010);
    clear_all(); send_rsp(1'b1, 2'd0, 8'd48, 1'b1, 6'd17, 7'h15);
    check("R3 auto crc", 32'(err_detail), 32'h020);
    clear_all(); send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd3, 7'h2a);
    check("R4 normal index", 32'(err_detail), 32'h100);
    clear_all(); send_rsp(1'b1, 2'd3, 8'd48, 1'b1, 6'd3, 7'h2a);
    check("R4 auto index", 32'(err_detail), 32'h200);
    clear_all(); send_rsp(1'b0, 2'd1, 8'd136, 1'b1, 6'd3, 7'h15);
    check("R4 long kind skips index and crc", 32'(err_detail), 32'h0);
    clear_all(); send_rsp(1'b1, 2'd2, 8'd48, 1'b1, 6'd3, 7'h15);
    check("R4 bare kind skips index and crc", 32'(err_detail), 32'h0);
  endtask

  task automatic t_read();
    clear_all(); send_rd(1'b0, 14'd4112, 4'b0001, 64'hffff_0000_0000_0000);
    check("R6 narrow ignores upper lanes", 32'(err_detail), 32'h0);
    clear_all(); send_rd(1'b1, 14'd1040, 4'hf, 64'h0001_0000_0000_0000);
    check("R6 wide lane 3 crc", 32'(err_detail), 32'h040);
    clear_all(); send_rd(1'b0, 14'd1040, 4'hf, 64'h0);
    check("R5 narrow length", 32'(err_detail), 32'h004);
    clear_all(); send_rd(1'b1, 14'd1040, 4'b1011, 64'h0);
    check("R5 wide lane 2 end bit", 32'(err_detail), 32'h004);
    clear_all(); send_rd(1'b1, 14'd4112, 4'hf, 64'h0);
    check("R5 wide length", 32'(err_detail), 32'h004);
  endtask

  task automatic t_token();
    clear_all(); send_tok(3'd3, 1'b1, 3'b010);
    check("R7 good token", 32'(err_detail), 32'h0);
    clear_all(); send_tok(3'd3, 1'b1, 3'b101);
    check("R7 token pattern", 32'(err_detail), 32'h080);
    clear_all(); send_tok(3'd4, 1'b1, 3'b010);
    check("R7 token length", 32'(err_detail), 32'h008);
    clear_all(); send_tok(3'd3, 1'b0, 3'b010);
    check("R7 token end bit", 32'(err_detail), 32'h008);
  endtask

  task automatic t_summary();
    clear_all();
    send_rsp(1'b1, 2'd0, 8'd40, 1'b1, 6'd17, 7'h2a);
    send_rd(1'b1, 14'd1040, 4'hf, 64'h0000_0000_0010_0000);
    check("R8 summary bits", 32'(err_sum), 32'h3);
    irq_en = 3'b010; #1;
    check("R8 irq enabled", 32'(irq), 32'h1);
    irq_en = 3'b100; #1;
    check("R8 irq masked", 32'(irq), 32'h0);
    send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd4, 7'h2a);
    check("R8 index summary", 32'(err_sum), 32'h7);
    check("R8 irq index", 32'(irq), 32'h1);
    irq_en = 3'b000;
  endtask

  task automatic t_sticky();
    clear_all(); send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd1, 7'h2a);
    send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd17, 7'h2a);
    send_tok(3'd3, 1'b1, 3'b010);
    check("R9 bit holds over good frames", 32'(err_detail), 32'h100);
    send_tok(3'd3, 1'b1, 3'b111);
    check("R9 bits accumulate", 32'(err_detail), 32'h180);
  endtask

  task automatic t_clear();
    clear_all();
    check("R10 command write clears", 32'(err_detail), 32'h0);
    send_tok(3'd2, 1'b1, 3'b010);
    core_run = 1'b0;
    @(negedge clk);
    core_run = 1'b1;
    check("R10 halt clears", 32'(err_detail), 32'h0);
    send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd9, 7'h2a);
    cmd_wr = 1'b1;
    send_rsp(1'b0, 2'd0, 8'd48, 1'b1, 6'd17, 7'h01);
    cmd_wr = 1'b0;
    check("R10 new error wins over clear", 32'(err_detail), 32'h010);
  endtask

  task automatic t_timing();
    clear_all();
    tok_bits = 3'b000; tok_len = 3'd3; tok_end = 1'b1; tok_done = 1'b1;
    @(posedge clk); #1;
    check("R11 set at strobe edge", 32'(err_detail), 32'h080);
    tok_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rsp();
    t_read();
    t_token();
    t_summary();
    t_sticky();
    t_clear();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule